// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch state of every hardware thread in a multithreaded front end, together with one stage-wide active flag. Each cycle it collects block and unblock strobes from four downstream stages (decode, rename, execute, commit), redirect requests from commit and from decode that carry a new PC, next PC and micro-PC, a per-thread "reorder buffer still squashing" flag and a global context-switch flag. It then resolves them in a fixed priority order. It also accepts per-thread fetch-side events from the instruction-cache path: miss issued, no miss slot, retry accepted, response returned, translation fault, quiesce, wake. It reports each thread's state and redirect target, and raises one-cycle pulses when the whole stage wakes or goes to sleep.

The thread state machine has nine named states. Running (code 0) is the normal fetching state. Idle (1) waits for a redirect after a trap. Squashing (2) is held while a redirect drains. Blocked (3) means a stall is present. WaitResponse (4) has an instruction-cache access outstanding. WaitRetry (5) waits for a miss slot. AccessComplete (6) has a returned line waiting to be used. TrapPending (7) follows a translation fault. QuiescePending (8) follows a quiesce.

The named transitions are:
- commit-redirect: any state to Squashing.
- rob-hold: any state to Squashing.
- decode-redirect: any state except Squashing, to Squashing.
- stall: any state except WaitResponse and WaitRetry, to Blocked.
- release: Blocked or Squashing to Running.
- miss: Running to WaitResponse.
- no-slot: Running to WaitRetry.
- retry-ok: WaitRetry to WaitResponse.
- response: WaitResponse to AccessComplete, or to Blocked when stalled.
- consume: AccessComplete to Running.
- fault: Running to TrapPending.
- quiesce: Running to QuiescePending.
- wake: QuiescePending to Running, or TrapPending to Idle.

Top module: `fetch_status_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every thread is in Running, with all stall flags clear and PC, next PC and micro-PC zero. The stage is active and neither pulse is raised. State codes are: Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8.
- R2: Each thread t has four stall flags at bit t*4+s of the strobe and flag vectors, where s is 0 for decode, 1 for rename, 2 for execute and 3 for commit. A block strobe sets its flag at the next edge and an unblock strobe clears it. An unblock strobe is legal only when its flag is already set and its block strobe is low in the same cycle.
- R3: A thread counts as stalled when the context-switch input is high or any of its four flags is set after this cycle's strobes are applied.
- R4: A commit redirect loads the commit PC, next PC and micro-PC and moves the thread to Squashing at the next edge, from any state. It has the highest priority.
- R5: When there is no commit redirect, the reorder-buffer-squashing flag moves the thread to Squashing and leaves its PC unchanged.
- R6: When neither R4 nor R5 applies, a decode redirect loads the decode PC, next PC and micro-PC and moves the thread to Squashing. If the thread is already in Squashing, the decode redirect is ignored and the lower rules are applied instead.
- R7: When none of R4 to R6 applies, a stalled thread moves to Blocked, except that WaitResponse and WaitRetry are kept.
- R8: When none of R4 to R7 applies, a thread in Blocked or Squashing returns to Running.
- R9: A fetch event is applied only in a cycle where none of R4 to R8 changed the thread. The event codes are: 0 none, 1 miss, 2 no-slot, 3 retry-ok, 4 response, 5 fault, 6 quiesce, 7 wake. An event that arrives in a state where it has no transition is ignored. In Running, miss moves the thread to WaitResponse and no-slot moves it to WaitRetry. In WaitRetry, retry-ok moves it to WaitResponse.
- R10: A response in WaitResponse moves the thread to Blocked if it is stalled and to AccessComplete otherwise. A response that arrives in any other state, for example after a redirect, is ignored.
- R11: A thread in AccessComplete moves to Running in a cycle where its fetch-select bit is high. Without that bit it stays in AccessComplete.
- R12: In Running, a fault moves the thread to TrapPending and a quiesce moves it to QuiescePending. A wake moves QuiescePending to Running and TrapPending to Idle.
- R13: At each edge the stage-active output becomes 1 if any active thread's new state is Running, Squashing or AccessComplete, and 0 otherwise. A one-cycle wake pulse is raised on a 0-to-1 change and a sleep pulse on a 1-to-0 change.
- R14: For a thread whose active bit is low, strobes, redirects and events have no effect: its state, flags and PCs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active_i | input | NT | Thread active bits |
| blk_i | input | NT*4 | Block strobes, bit t*4+s |
| unblk_i | input | NT*4 | Unblock strobes, bit t*4+s |
| ctx_switch_i | input | 1 | Context switch in progress |
| cmt_squash_i | input | NT | Commit redirect per thread |
| cmt_pc_i | input | NT*PC_W | Commit redirect PC |
| cmt_npc_i | input | NT*PC_W | Commit redirect next PC |
| cmt_upc_i | input | NT*UPC_W | Commit redirect micro-PC |
| rob_squashing_i | input | NT | Reorder buffer still squashing |
| dec_squash_i | input | NT | Decode redirect per thread |
| dec_pc_i | input | NT*PC_W | Decode redirect PC |
| dec_npc_i | input | NT*PC_W | Decode redirect next PC |
| dec_upc_i | input | NT*UPC_W | Decode redirect micro-PC |
| fetch_evt_i | input | NT*3 | Fetch-side event code per thread |
| fetch_sel_i | input | NT | Thread selected for fetch this cycle |
| thr_state_o | output | NT*4 | State code per thread |
| thr_pc_o | output | NT*PC_W | Current PC per thread |
| thr_npc_o | output | NT*PC_W | Current next PC per thread |
| thr_upc_o | output | NT*UPC_W | Current micro-PC per thread |
| stall_flags_o | output | NT*4 | Stall flags, bit t*4+s |
| stage_active_o | output | 1 | Stage active flag |
| stage_wake_o | output | 1 | Pulse on inactive-to-active |
| stage_sleep_o | output | 1 | Pulse on active-to-inactive |

## Verification
The embedded assertions check the following on every cycle:
- a commit redirect always lands in Squashing with the commit target loaded;
- the reorder-buffer hold keeps the PC untouched;
- an outstanding cache access is never dropped by a stall;
- an inactive thread never moves;
- the wake and sleep pulses are exclusive and coincide with real changes of the active flag;
- unblock strobes are only seen while their flag is set.

The bench's scenarios show what a single-cycle property cannot. These are the interplay of rules in one cycle, such as a decode redirect ignored while Squashing that then falls through to release. They also include a stale response after a redirect, the full cache-miss round trip with and without a stall, and the trap, idle and redirect path. The bench compares every thread against a behavioural model on each clock, including during a long mixed-stimulus run.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int NUM_STAGES = 4;
    localparam int STATE_W    = 4;
    localparam int EVT_W      = 3;

    typedef enum logic [STATE_W-1:0] {
        TS_RUN       = 4'd0,
        TS_IDLE      = 4'd1,
        TS_SQUASH    = 4'd2,
        TS_BLOCKED   = 4'd3,
        TS_WAIT_RESP = 4'd4,
        TS_WAIT_RTRY = 4'd5,
        TS_ACC_DONE  = 4'd6,
        TS_TRAP      = 4'd7,
        TS_QUIESCE   = 4'd8
    } tstate_e;

    typedef enum logic [EVT_W-1:0] {
        EV_NONE     = 3'd0,
        EV_MISS     = 3'd1,
        EV_NOSLOT   = 3'd2,
        EV_RETRY_OK = 3'd3,
        EV_RESP     = 3'd4,
        EV_FAULT    = 3'd5,
        EV_QUIESCE  = 3'd6,
        EV_WAKE     = 3'd7
    } fevt_e;

    function automatic logic keeps_stage_awake(tstate_e s);
        return (s == TS_RUN) || (s == TS_SQUASH) || (s == TS_ACC_DONE);
    endfunction

endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
    parameter int NSTG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [NSTG-1:0] set_i,
    input  logic [NSTG-1:0] clr_i,
    output logic [NSTG-1:0] flags_o,
    output logic [NSTG-1:0] flags_nx_o
);

    logic [NSTG-1:0] flags_q;

    always_comb begin
        flags_nx_o = flags_q;
        if (en_i) begin
            flags_nx_o = (flags_q | set_i) & ~clr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_nx_o;
        end
    end

    assign flags_o = flags_q;

    // R2: an unblock strobe only arrives for a raised flag without its block strobe
    p_unblock_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (clr_i != '0)) |-> (((clr_i & ~flags_q) == '0) && ((clr_i & set_i) == '0)));

    // R2: a block strobe leaves its flag raised after the edge
    p_block_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ((set_i & clr_i) == '0)) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R14: flags of an inactive thread stay put
    p_flags_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(flags_q));

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int UPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             stalled_i,
    input  logic             cmt_sq_i,
    input  logic [PC_W-1:0]  cmt_pc_i,
    input  logic [PC_W-1:0]  cmt_npc_i,
    input  logic [UPC_W-1:0] cmt_upc_i,
    input  logic             rob_sq_i,
    input  logic             dec_sq_i,
    input  logic [PC_W-1:0]  dec_pc_i,
    input  logic [PC_W-1:0]  dec_npc_i,
    input  logic [UPC_W-1:0] dec_upc_i,
    input  fevt_e            evt_i,
    input  logic             sel_i,
    output tstate_e          state_o,
    output tstate_e          state_nx_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  npc_o,
    output logic [UPC_W-1:0] upc_o
);

    tstate_e          st_q, st_nx;
    logic [PC_W-1:0]  pc_q, pc_nx, npc_q, npc_nx;
    logic [UPC_W-1:0] upc_q, upc_nx;

    // Next-state process: fixed rule chain, then fetch events
    always_comb begin
        st_nx  = st_q;
        pc_nx  = pc_q;
        npc_nx = npc_q;
        upc_nx = upc_q;
        if (en_i) begin
            if (cmt_sq_i) begin
                st_nx  = TS_SQUASH;
                pc_nx  = cmt_pc_i;
                npc_nx = cmt_npc_i;
                upc_nx = cmt_upc_i;
            end else if (rob_sq_i) begin
                st_nx = TS_SQUASH;
            end else if (dec_sq_i && (st_q != TS_SQUASH)) begin
                st_nx  = TS_SQUASH;
                pc_nx  = dec_pc_i;
                npc_nx = dec_npc_i;
                upc_nx = dec_upc_i;
            end else if (stalled_i && (st_q != TS_WAIT_RESP) && (st_q != TS_WAIT_RTRY)) begin
                st_nx = TS_BLOCKED;
            end else if ((st_q == TS_BLOCKED) || (st_q == TS_SQUASH)) begin
                st_nx = TS_RUN;
            end else begin
                unique case (st_q)
                    TS_RUN: begin
                        if (evt_i == EV_MISS)         st_nx = TS_WAIT_RESP;
                        else if (evt_i == EV_NOSLOT)  st_nx = TS_WAIT_RTRY;
                        else if (evt_i == EV_FAULT)   st_nx = TS_TRAP;
                        else if (evt_i == EV_QUIESCE) st_nx = TS_QUIESCE;
                    end
                    TS_WAIT_RTRY: begin
                        if (evt_i == EV_RETRY_OK) st_nx = TS_WAIT_RESP;
                    end
                    TS_WAIT_RESP: begin
                        if (evt_i == EV_RESP) st_nx = stalled_i ? TS_BLOCKED : TS_ACC_DONE;
                    end
                    TS_ACC_DONE: begin
                        if (sel_i) st_nx = TS_RUN;
                    end
                    TS_TRAP: begin
                        if (evt_i == EV_WAKE) st_nx = TS_IDLE;
                    end
                    TS_QUIESCE: begin
                        if (evt_i == EV_WAKE) st_nx = TS_RUN;
                    end
                    default: st_nx = st_q;
                endcase
            end
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TS_RUN;
            pc_q  <= '0;
            npc_q <= '0;
            upc_q <= '0;
        end else begin
            st_q  <= st_nx;
            pc_q  <= pc_nx;
            npc_q <= npc_nx;
            upc_q <= upc_nx;
        end
    end

    // Output process
    always_comb begin
        state_o    = st_q;
        state_nx_o = st_nx;
        pc_o       = pc_q;
        npc_o      = npc_q;
        upc_o      = upc_q;
    end

    p_cmt_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cmt_sq_i) |=> ((st_q == TS_SQUASH) && (pc_q == $past(cmt_pc_i))
                                && (npc_q == $past(cmt_npc_i)) && (upc_q == $past(cmt_upc_i))));

    p_rob_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cmt_sq_i && rob_sq_i) |=> ((st_q == TS_SQUASH) && $stable(pc_q)));

    p_inflight_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cmt_sq_i && !rob_sq_i && !dec_sq_i && (evt_i == EV_NONE)
         && ((st_q == TS_WAIT_RESP) || (st_q == TS_WAIT_RTRY))) |=> $stable(st_q));

    p_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cmt_sq_i && !rob_sq_i && !dec_sq_i && !stalled_i && sel_i
         && (st_q == TS_ACC_DONE)) |=> (st_q == TS_RUN));

    p_inactive_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(st_q) && $stable(pc_q) && $stable(npc_q) && $stable(upc_q)));

endmodule

// File: rtl/fsc_stage_act.sv
module fsc_stage_act #(
    parameter int NT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] awake_i,
    output logic          active_o,
    output logic          wake_o,
    output logic          sleep_o
);

    logic act_q, wake_q, sleep_q;
    logic act_nx;

    always_comb begin
        act_nx = |awake_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b1;
            wake_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            act_q   <= act_nx;
            wake_q  <= act_nx & ~act_q;
            sleep_q <= ~act_nx & act_q;
        end
    end

    assign active_o = act_q;
    assign wake_o   = wake_q;
    assign sleep_o  = sleep_q;

    p_pulse_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_q, sleep_q}));

    p_wake_edge_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (|awake_i) |=> (act_q && (wake_q == !$past(act_q))));

    p_sleep_edge_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(|awake_i) |=> (!act_q && (sleep_q == $past(act_q))));

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NT    = 2,
    parameter int PC_W  = 32,
    parameter int UPC_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NT-1:0]               thr_active_i,
    input  logic [NT*NUM_STAGES-1:0]    blk_i,
    input  logic [NT*NUM_STAGES-1:0]    unblk_i,
    input  logic                        ctx_switch_i,
    input  logic [NT-1:0]               cmt_squash_i,
    input  logic [NT*PC_W-1:0]          cmt_pc_i,
    input  logic [NT*PC_W-1:0]          cmt_npc_i,
    input  logic [NT*UPC_W-1:0]         cmt_upc_i,
    input  logic [NT-1:0]               rob_squashing_i,
    input  logic [NT-1:0]               dec_squash_i,
    input  logic [NT*PC_W-1:0]          dec_pc_i,
    input  logic [NT*PC_W-1:0]          dec_npc_i,
    input  logic [NT*UPC_W-1:0]         dec_upc_i,
    input  logic [NT*EVT_W-1:0]         fetch_evt_i,
    input  logic [NT-1:0]               fetch_sel_i,
    output logic [NT*STATE_W-1:0]       thr_state_o,
    output logic [NT*PC_W-1:0]          thr_pc_o,
    output logic [NT*PC_W-1:0]          thr_npc_o,
    output logic [NT*UPC_W-1:0]         thr_upc_o,
    output logic [NT*NUM_STAGES-1:0]    stall_flags_o,
    output logic                        stage_active_o,
    output logic                        stage_wake_o,
    output logic                        stage_sleep_o
);

    localparam int NS = NUM_STAGES;

    logic [NT-1:0] awake;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [NS-1:0] flags_nx;
        logic          stalled;
        tstate_e       st, st_nx;

        fsc_stall_flags #(.NSTG(NS)) u_flags (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (thr_active_i[t]),
            .set_i      (blk_i[t*NS +: NS]),
            .clr_i      (unblk_i[t*NS +: NS]),
            .flags_o    (stall_flags_o[t*NS +: NS]),
            .flags_nx_o (flags_nx)
        );

        assign stalled = ctx_switch_i | (|flags_nx);

        fsc_thread_fsm #(.PC_W(PC_W), .UPC_W(UPC_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (thr_active_i[t]),
            .stalled_i  (stalled),
            .cmt_sq_i   (cmt_squash_i[t]),
            .cmt_pc_i   (cmt_pc_i[t*PC_W +: PC_W]),
            .cmt_npc_i  (cmt_npc_i[t*PC_W +: PC_W]),
            .cmt_upc_i  (cmt_upc_i[t*UPC_W +: UPC_W]),
            .rob_sq_i   (rob_squashing_i[t]),
            .dec_sq_i   (dec_squash_i[t]),
            .dec_pc_i   (dec_pc_i[t*PC_W +: PC_W]),
            .dec_npc_i  (dec_npc_i[t*PC_W +: PC_W]),
            .dec_upc_i  (dec_upc_i[t*UPC_W +: UPC_W]),
            .evt_i      (fevt_e'(fetch_evt_i[t*EVT_W +: EVT_W])),
            .sel_i      (fetch_sel_i[t]),
            .state_o    (st),
            .state_nx_o (st_nx),
            .pc_o       (thr_pc_o[t*PC_W +: PC_W]),
            .npc_o      (thr_npc_o[t*PC_W +: PC_W]),
            .upc_o      (thr_upc_o[t*UPC_W +: UPC_W])
        );

        assign thr_state_o[t*STATE_W +: STATE_W] = st;
        assign awake[t] = thr_active_i[t] & keeps_stage_awake(st_nx);
    end

    fsc_stage_act #(.NT(NT)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .awake_i  (awake),
        .active_o (stage_active_o),
        .wake_o   (stage_wake_o),
        .sleep_o  (stage_sleep_o)
    );

endmodule

// File: tb/fetch_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_status_ctrl_tb_top;

    localparam int NT = 2, PW = 32, UW = 8;
    localparam int S_RUN = 0, S_IDLE = 1, S_SQ = 2, S_BLK = 3, S_WRSP = 4,
                   S_WRTY = 5, S_ACC = 6, S_TRAP = 7, S_QUI = 8;
    localparam int E_NONE = 0, E_MISS = 1, E_NOSLOT = 2, E_ROK = 3, E_RESP = 4,
                   E_FAULT = 5, E_QUI = 6, E_WAKE = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NT-1:0]    act_v;
    logic [NT*4-1:0]  blk, unblk;
    logic             ctx;
    logic [NT-1:0]    cmt_sq, rob_sq, dec_sq, sel;
    logic [NT*PW-1:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
    logic [NT*UW-1:0] cmt_upc, dec_upc;
    logic [NT*3-1:0]  fevt;
    logic [NT*4-1:0]  st_o, fl_o;
    logic [NT*PW-1:0] pc_o, npc_o;
    logic [NT*UW-1:0] upc_o;
    logic             sact_o, swake_o, ssleep_o;

    fetch_status_ctrl #(.NT(NT), .PC_W(PW), .UPC_W(UW)) dut_i (
        .clk(clk), .rst_n(rst_n), .thr_active_i(act_v), .blk_i(blk), .unblk_i(unblk),
        .ctx_switch_i(ctx), .cmt_squash_i(cmt_sq), .cmt_pc_i(cmt_pc), .cmt_npc_i(cmt_npc),
        .cmt_upc_i(cmt_upc), .rob_squashing_i(rob_sq), .dec_squash_i(dec_sq),
        .dec_pc_i(dec_pc), .dec_npc_i(dec_npc), .dec_upc_i(dec_upc), .fetch_evt_i(fevt),
        .fetch_sel_i(sel), .thr_state_o(st_o), .thr_pc_o(pc_o), .thr_npc_o(npc_o),
        .thr_upc_o(upc_o), .stall_flags_o(fl_o), .stage_active_o(sact_o),
        .stage_wake_o(swake_o), .stage_sleep_o(ssleep_o)
    );

    // Behavioural reference state
    int       m_st[NT];
    longint   m_pc[NT], m_npc[NT], m_upc[NT];
    bit [3:0] m_fl[NT];
    bit       m_act, m_up, m_dn;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    task automatic chk(string what, longint actual, longint expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, what, actual, expected);
        end
    endtask

    function automatic int on_event(int s, int ev, bit stl, bit sl);
        case (s)
            S_RUN:  return (ev == E_MISS) ? S_WRSP : (ev == E_NOSLOT) ? S_WRTY :
                           (ev == E_FAULT) ? S_TRAP : (ev == E_QUI) ? S_QUI : s;
            S_WRTY: return (ev == E_ROK) ? S_WRSP : s;
            S_WRSP: return (ev == E_RESP) ? (stl ? S_BLK : S_ACC) : s;
            S_ACC:  return sl ? S_RUN : s;
            S_TRAP: return (ev == E_WAKE) ? S_IDLE : s;
            S_QUI:  return (ev == E_WAKE) ? S_RUN : s;
            default: return s;
        endcase
    endfunction

    task automatic model_update();
        bit any_awake = 0;
        for (int t = 0; t < NT; t++) begin
            if (act_v[t]) begin
                int ns;
                bit stl;
                m_fl[t] = (m_fl[t] | blk[t*4 +: 4]) & ~unblk[t*4 +: 4];
                stl = ctx || (m_fl[t] != 0);
                ns = m_st[t];
                if (cmt_sq[t]) begin
                    ns = S_SQ;
                    m_pc[t] = cmt_pc[t*PW +: PW]; m_npc[t] = cmt_npc[t*PW +: PW];
                    m_upc[t] = cmt_upc[t*UW +: UW];
                end else if (rob_sq[t]) begin
                    ns = S_SQ;
                end else if (dec_sq[t] && m_st[t] != S_SQ) begin
                    ns = S_SQ;
                    m_pc[t] = dec_pc[t*PW +: PW]; m_npc[t] = dec_npc[t*PW +: PW];
                    m_upc[t] = dec_upc[t*UW +: UW];
                end else if (stl && m_st[t] != S_WRSP && m_st[t] != S_WRTY) begin
                    ns = S_BLK;
                end else if (m_st[t] == S_BLK || m_st[t] == S_SQ) begin
                    ns = S_RUN;
                end else begin
                    ns = on_event(m_st[t], int'(fevt[t*3 +: 3]), stl, sel[t]);
                end
                m_st[t] = ns;
            end
        end
        for (int t = 0; t < NT; t++)
            if (act_v[t] && (m_st[t] == S_RUN || m_st[t] == S_SQ || m_st[t] == S_ACC))
                any_awake = 1;
        m_up = any_awake && !m_act;
        m_dn = !any_awake && m_act;
        m_act = any_awake;
    endtask

    task automatic compare_all();
        for (int t = 0; t < NT; t++) begin
            chk($sformatf("t%0d state", t), longint'(st_o[t*4 +: 4]), longint'(m_st[t]));
            chk($sformatf("t%0d pc", t), longint'(pc_o[t*PW +: PW]), m_pc[t]);
            chk($sformatf("t%0d npc", t), longint'(npc_o[t*PW +: PW]), m_npc[t]);
            chk($sformatf("t%0d upc", t), longint'(upc_o[t*UW +: UW]), m_upc[t]);
            chk($sformatf("t%0d flags", t), longint'(fl_o[t*4 +: 4]), longint'(m_fl[t]));
        end
        chk("stage active", longint'(sact_o), longint'(m_act));
        chk("wake pulse", longint'(swake_o), longint'(m_up));
        chk("sleep pulse", longint'(ssleep_o), longint'(m_dn));
    endtask

    task automatic quiet();
        blk = '0; unblk = '0; ctx = 0; cmt_sq = '0; rob_sq = '0; dec_sq = '0;
        fevt = '0; sel = '0;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic evt(int t, int e);
        fevt[t*3 +: 3] = 3'(e);
    endtask

    task automatic set_cmt(int t, longint pc, longint up);
        cmt_sq[t] = 1; cmt_pc[t*PW +: PW] = PW'(pc); cmt_npc[t*PW +: PW] = PW'(pc + 4);
        cmt_upc[t*UW +: UW] = UW'(up);
    endtask

    task automatic set_dec(int t, longint pc, longint up);
        dec_sq[t] = 1; dec_pc[t*PW +: PW] = PW'(pc); dec_npc[t*PW +: PW] = PW'(pc + 8);
        dec_upc[t*UW +: UW] = UW'(up);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        act_v = '1; quiet();
        cmt_pc = '0; cmt_npc = '0; cmt_upc = '0; dec_pc = '0; dec_npc = '0; dec_upc = '0;
        for (int t = 0; t < NT; t++) begin
            m_st[t] = S_RUN; m_pc[t] = 0; m_npc[t] = 0; m_upc[t] = 0; m_fl[t] = 0;
        end
        m_act = 1; m_up = 0; m_dn = 0;
        repeat (3) @(negedge clk);
        // R1: reset values during reset, then after release
        cur_req = "R1";
        chk("reset t0 state", longint'(st_o[3:0]), S_RUN);
        chk("reset flags", longint'(fl_o), 0);
        chk("reset active", longint'(sact_o), 1);
        rst_n = 1;
        @(negedge clk);
        compare_all();

        // R2 / R7: decode-stage block stalls thread 0
        cur_req = "R2";
        blk[0] = 1; step();
        cur_req = "R7";
        blk[1] = 1; step();
        cur_req = "R2";
        unblk[0] = 1; step();
        // R8: release once the last flag drops
        cur_req = "R8";
        unblk[1] = 1; step();
        step();

        // R3 / R13: context switch blocks both threads, stage sleeps then wakes
        cur_req = "R3";
        ctx = 1; step();
        cur_req = "R13";
        step();
        step();

        // R4: commit redirect on thread 1, then release
        cur_req = "R4";
        set_cmt(1, 64'h100, 3); step();
        cur_req = "R8";
        step();

        // R5: rob hold keeps the PC; rob beats a decode redirect
        cur_req = "R5";
        rob_sq[0] = 1; step();
        rob_sq[0] = 1; set_dec(0, 64'h900, 1); step();
        step();

        // R6: decode redirect, then a second one while Squashing is ignored
        cur_req = "R6";
        set_dec(0, 64'h2000, 5); step();
        set_dec(0, 64'h3000, 6); step();
        // R4 beats a decode redirect in the same cycle
        cur_req = "R4";
        set_cmt(0, 64'h4000, 2); set_dec(0, 64'h5000, 7); step();
        step();

        // R9 / R7 / R10: miss round trip with a stall while waiting
        cur_req = "R9";
        evt(0, E_MISS); step();
        cur_req = "R7";
        blk[2] = 1; step();
        step();
        cur_req = "R10";
        evt(0, E_RESP); step();
        unblk[2] = 1; step();
        cur_req = "R11";
        evt(0, E_MISS); step();
        evt(0, E_RESP); step();
        step();
        sel[0] = 1; step();

        // R10: stale response after a redirect is ignored
        cur_req = "R10";
        evt(1, E_MISS); step();
        set_cmt(1, 64'h7000, 0); step();
        evt(1, E_RESP); step();
        evt(1, E_RESP); step();

        // R9: no-slot path and retry
        cur_req = "R9";
        evt(1, E_NOSLOT); step();
        step();
        evt(1, E_ROK); step();
        evt(1, E_RESP); sel[1] = 1; step();
        sel[1] = 1; step();

        // R12: fault, wake to Idle, redirect back; quiesce and wake
        cur_req = "R12";
        evt(0, E_FAULT); step();
        evt(0, E_WAKE); step();
        set_cmt(0, 64'h8000, 4); step();
        step();
        evt(0, E_QUI); step();
        evt(0, E_WAKE); step();

        // R14: inactive thread ignores everything; R13 stage sleeps
        cur_req = "R14";
        act_v[1] = 0;
        blk[4] = 1; set_cmt(1, 64'hdead0, 9); evt(1, E_FAULT); step();
        cur_req = "R13";
        evt(0, E_FAULT); step();
        evt(0, E_WAKE); step();
        set_cmt(0, 64'ha000, 0); step();
        act_v[1] = 1; step();

        // R9: long mixed legal stimulus, compared each clock
        cur_req = "R9";
        for (int i = 0; i < 600; i++) begin
            for (int t = 0; t < NT; t++) begin
                if (($urandom % 40) == 0) act_v[t] = ~act_v[t];
                for (int s = 0; s < 4; s++) begin
                    int r = $urandom % 8;
                    if (m_fl[t][s] && r == 0) unblk[t*4+s] = 1;
                    else if (!m_fl[t][s] && r == 1) blk[t*4+s] = 1;
                end
                if (($urandom % 12) == 0) set_cmt(t, longint'($urandom), $urandom % 256);
                if (($urandom % 12) == 0) rob_sq[t] = 1;
                if (($urandom % 8) == 0) set_dec(t, longint'($urandom), $urandom % 256);
                evt(t, $urandom % 8);
                sel[t] = ($urandom % 2) == 1;
            end
            ctx = ($urandom % 25) == 0;
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule